// File: doc/BRIEF.md
# Link Transport Frame Assembler for Decimated Dual-Channel Samples

This block sits between the decimation stage of a two-channel data converter and the serial link layer. For each frame it takes one group of 16-bit samples from channel A and channel B, using a valid/ready handshake. It then serialises them as octets onto up to eight lanes, four per channel, sending one octet per lane on every octet clock. A 3-bit mode code selects one of six decimated link layouts. These cover real and I/Q data, one or two lanes per channel, and a layout in which a single lane carries both channels. The frame length is 2 or 4 octets, depending on the mode. A frame-start flag marks the first octet of every frame.

Each channel presents two words per frame, `*_first` and `*_second`. Under 2x decimation they are the older and the newer sample. Under 4x I/Q decimation they are the I word and the Q word. Under 4x real decimation only `*_first` is used.

The design is a two-state controller. In `ST_IDLE` no frame is buffered, `smp_ready` is high and the mode code is latched on every cycle. In `ST_SEND` the buffered frame is serialised, one octet per cycle. The controller has three named transitions:
- T_START (`ST_IDLE` to `ST_SEND`) happens when a frame is accepted.
- T_CHAIN (`ST_SEND` to `ST_SEND`) happens when a new frame is accepted on the final octet, so frames follow with no gap.
- T_DRAIN (`ST_SEND` to `ST_IDLE`) happens on the final octet when no frame is offered.

Top module: `jfa_frame_assembler`

## Requirements
- R1: Every 16-bit word is sent as two consecutive octets on its lane, with bits [15:8] first and then bits [7:0].
- R2: In mode code 0 (four lanes, two per channel, 2-octet frame, 2x decimation), `a_first` goes on lane index 1 and `a_second` goes on lane index 0. `b_first` goes on lane index 5 and `b_second` goes on lane index 4.
- R3: In mode code 1 (two lanes, 4-octet frame, 2x decimation), lane 1 carries `a_first` and then `a_second`. Lane 5 carries `b_first` and then `b_second`.
- R4: In mode code 2 (two lanes, 2-octet frame, 4x real), lane 1 carries `a_first` and lane 5 carries `b_first`. The `*_second` inputs have no effect on the outputs.
- R5: In mode code 3 (two lanes, 4-octet frame, 4x I/Q), lane 1 carries the I word (`a_first`) and then the Q word (`a_second`). Lane 5 carries `b_first` and then `b_second` in the same way.
- R6: In mode code 4 (four lanes, 2-octet frame, 4x I/Q), the I word goes on lane 1 (or lane 5) and the Q word goes on lane 0 (or lane 4).
- R7: In mode code 5 (one lane, 4-octet frame, lane share), lane 1 alone carries `a_first` and then `b_first`. No other lane is valid.
- R8: Lanes are indexed with channel A on indices 0 to 3 and channel B on indices 4 to 7. Lane indices 2, 3, 6 and 7 are never valid. Any lane that is not valid outputs octet 0x00. In `ST_IDLE` every lane is invalid.
- R9: `frame_start` is high on the first octet of every frame, and only then. It appears in the cycle after the frame is accepted.
- R10: `smp_ready` is high in `ST_IDLE` and on a frame's final octet, and low on every other octet. A frame accepted on the final octet starts in the next cycle, with no idle cycle in between.
- R11: The mode code is sampled only in `ST_IDLE`. A code change while frames are streaming, including across T_CHAIN, takes effect only after T_DRAIN.
- R12: Mode codes 6 and 7 behave exactly as mode code 0.
- R13: After reset, `smp_ready` is high, `frame_start` is low, and all lanes are invalid with octet 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Link layout code (0 to 5; 6 and 7 act as 0) |
| smp_valid | input | 1 | A frame's sample words are presented |
| smp_ready | output | 1 | Block accepts a frame this cycle |
| a_first | input | 16 | Channel A older sample or I word |
| a_second | input | 16 | Channel A newer sample or Q word |
| b_first | input | 16 | Channel B older sample or I word |
| b_second | input | 16 | Channel B newer sample or Q word |
| lane_octet | output | 64 | One octet per lane; lane n occupies bits [8n+7:8n] |
| lane_vld | output | 8 | Per-lane valid; bit n belongs to lane n |
| frame_start | output | 1 | First octet of a frame on all valid lanes |

## Verification
On every cycle, the assertions check the following:
- A frame start follows each accepted frame.
- `smp_ready` stays low inside 4-octet frames.
- The latched mode holds while `ST_SEND` lasts.
- The unused upper lanes never become valid.
- Lane share drives exactly one lane.
- Every frame start has at least one valid lane.

Only the bench's scenarios can show that the octet values land on the right lanes in the right order for each of the six layouts. The same holds for the fallback of codes 6 and 7, for back-to-back frames through T_CHAIN, and for the way a mid-stream mode change is ignored until the stream drains.

// File: rtl/jfa_pkg.sv
package jfa_pkg;

    localparam int SMP_W = 16;

    typedef enum logic [2:0] {
        MD_2X_QUAD    = 3'd0,
        MD_2X_DUAL    = 3'd1,
        MD_4X_DUAL    = 3'd2,
        MD_4X_IQ_DUAL = 3'd3,
        MD_4X_IQ_QUAD = 3'd4,
        MD_4X_SHARE   = 3'd5
    } lmfs_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } fsm_e;

    // Unsupported codes fold onto the four-lane 2x layout.
    function automatic lmfs_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return MD_2X_DUAL;
            3'd2:    return MD_4X_DUAL;
            3'd3:    return MD_4X_IQ_DUAL;
            3'd4:    return MD_4X_IQ_QUAD;
            3'd5:    return MD_4X_SHARE;
            default: return MD_2X_QUAD;
        endcase
    endfunction

    // Index of the final octet of a frame: F-1.
    function automatic logic [1:0] last_octet(input lmfs_mode_e m);
        case (m)
            MD_2X_DUAL, MD_4X_IQ_DUAL, MD_4X_SHARE: return 2'd3;
            default:                                return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/jfa_ctrl.sv
module jfa_ctrl
    import jfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       smp_valid,
    output logic       smp_ready,
    output logic       load,
    output logic       active,
    output logic [1:0] octet_idx,
    output lmfs_mode_e mode_q,
    output logic       frame_start
);

    fsm_e       state_q, state_d;
    logic [1:0] idx_q, idx_d;
    logic       last_hit;

    assign last_hit  = (state_q == ST_SEND) && (idx_q == last_octet(mode_q));
    assign smp_ready = (state_q == ST_IDLE) || last_hit;
    assign load      = smp_valid && smp_ready;

    always_comb begin
        state_d = state_q;
        idx_d   = 2'd0;
        unique case (state_q)
            ST_IDLE: begin
                if (load) state_d = ST_SEND;           // T_START
            end
            ST_SEND: begin
                if (last_hit) begin
                    state_d = load ? ST_SEND : ST_IDLE; // T_CHAIN / T_DRAIN
                end else begin
                    idx_d = idx_q + 2'd1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= 2'd0;
            mode_q  <= MD_2X_QUAD;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (state_q == ST_IDLE) mode_q <= decode_mode(mode_sel);
        end
    end

    always_comb begin
        active      = (state_q == ST_SEND);
        octet_idx   = idx_q;
        frame_start = (state_q == ST_SEND) && (idx_q == 2'd0);
    end

    assert_sof_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> frame_start);

    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |=> $stable(mode_q));

    assert_no_ready_midframe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && last_octet(mode_q) == 2'd3) |-> !smp_ready);

endmodule

// File: rtl/jfa_sample_buf.sv
module jfa_sample_buf
    import jfa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SMP_W-1:0] a_first,
    input  logic [SMP_W-1:0] a_second,
    input  logic [SMP_W-1:0] b_first,
    input  logic [SMP_W-1:0] b_second,
    output logic [SMP_W-1:0] a0_q,
    output logic [SMP_W-1:0] a1_q,
    output logic [SMP_W-1:0] b0_q,
    output logic [SMP_W-1:0] b1_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a0_q <= '0;
            a1_q <= '0;
            b0_q <= '0;
            b1_q <= '0;
        end else if (load) begin
            a0_q <= a_first;
            a1_q <= a_second;
            b0_q <= b_first;
            b1_q <= b_second;
        end
    end

endmodule

// File: rtl/jfa_lane_map.sv
module jfa_lane_map
    import jfa_pkg::*;
#(
    parameter int LANES_PER_CH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  lmfs_mode_e                 mode_q,
    input  logic                       active,
    input  logic [1:0]                 octet_idx,
    input  logic [SMP_W-1:0]           a0_q,
    input  logic [SMP_W-1:0]           a1_q,
    input  logic [SMP_W-1:0]           b0_q,
    input  logic [SMP_W-1:0]           b1_q,
    output logic [2*LANES_PER_CH*8-1:0] lane_octet,
    output logic [2*LANES_PER_CH-1:0]   lane_vld
);

    localparam int NUM_LANES = 2 * LANES_PER_CH;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int CH  = g / LANES_PER_CH;
        localparam int POS = g % LANES_PER_CH;

        logic [SMP_W-1:0] w_first, w_second, word;
        logic             used;

        assign w_first  = (CH == 0) ? a0_q : b0_q;
        assign w_second = (CH == 0) ? a1_q : b1_q;

        always_comb begin
            word = '0;
            used = 1'b0;
            case (mode_q)
                MD_2X_QUAD, MD_4X_IQ_QUAD: begin
                    if (POS == 1) begin word = w_first;  used = 1'b1; end
                    if (POS == 0) begin word = w_second; used = 1'b1; end
                end
                MD_2X_DUAL, MD_4X_IQ_DUAL: begin
                    if (POS == 1) begin
                        word = octet_idx[1] ? w_second : w_first;
                        used = 1'b1;
                    end
                end
                MD_4X_DUAL: begin
                    if (POS == 1) begin word = w_first; used = 1'b1; end
                end
                MD_4X_SHARE: begin
                    if (CH == 0 && POS == 1) begin
                        word = octet_idx[1] ? b0_q : a0_q;
                        used = 1'b1;
                    end
                end
                default: begin
                    word = '0;
                    used = 1'b0;
                end
            endcase
        end

        assign lane_vld[g]           = active && used;
        assign lane_octet[g*8 +: 8] = lane_vld[g] ? (octet_idx[0] ? word[7:0] : word[15:8]) : 8'h00;

        if (POS >= 2) begin : g_upper
            assert_upper_lane_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !lane_vld[g]);
        end
    end

    assert_share_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mode_q == MD_4X_SHARE) |-> ($countones(lane_vld) == 1));

endmodule

// File: rtl/jfa_frame_assembler.sv
module jfa_frame_assembler
    import jfa_pkg::*;
#(
    parameter int LANES_PER_CH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  mode_sel,
    input  logic                        smp_valid,
    output logic                        smp_ready,
    input  logic [15:0]                 a_first,
    input  logic [15:0]                 a_second,
    input  logic [15:0]                 b_first,
    input  logic [15:0]                 b_second,
    output logic [2*LANES_PER_CH*8-1:0] lane_octet,
    output logic [2*LANES_PER_CH-1:0]   lane_vld,
    output logic                        frame_start
);

    logic             load, active;
    logic [1:0]       octet_idx;
    lmfs_mode_e       mode_q;
    logic [SMP_W-1:0] a0_q, a1_q, b0_q, b1_q;

    jfa_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .smp_valid  (smp_valid),
        .smp_ready  (smp_ready),
        .load       (load),
        .active     (active),
        .octet_idx  (octet_idx),
        .mode_q     (mode_q),
        .frame_start(frame_start)
    );

    jfa_sample_buf u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .a_first (a_first),
        .a_second(a_second),
        .b_first (b_first),
        .b_second(b_second),
        .a0_q    (a0_q),
        .a1_q    (a1_q),
        .b0_q    (b0_q),
        .b1_q    (b1_q)
    );

    jfa_lane_map #(.LANES_PER_CH(LANES_PER_CH)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_q    (mode_q),
        .active    (active),
        .octet_idx (octet_idx),
        .a0_q      (a0_q),
        .a1_q      (a1_q),
        .b0_q      (b0_q),
        .b1_q      (b1_q),
        .lane_octet(lane_octet),
        .lane_vld  (lane_vld)
    );

    assert_sof_on_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (lane_vld != '0));

endmodule

// File: tb/jfa_frame_assembler_bench.sv
module jfa_frame_assembler_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [15:0] a_first = '0, a_second = '0, b_first = '0, b_second = '0;
    logic [63:0] lane_octet;
    logic [7:0]  lane_vld;
    logic        frame_start;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jfa_frame_assembler u_jfa_frame_assembler (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .smp_valid(smp_valid), .smp_ready(smp_ready),
        .a_first(a_first), .a_second(a_second),
        .b_first(b_first), .b_second(b_second),
        .lane_octet(lane_octet), .lane_vld(lane_vld),
        .frame_start(frame_start)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int flen(input logic [2:0] m);
        return (m == 3'd1 || m == 3'd3 || m == 3'd5) ? 4 : 2;
    endfunction

    function automatic logic [7:0] pick(input logic [15:0] w, input int k);
        return (k % 2 == 0) ? w[15:8] : w[7:0];
    endfunction

    // Expected per-lane data and valid from the requirements.
    task automatic expect_octet(input logic [2:0] m, input int k,
                                input logic [15:0] a0, a1, b0, b1,
                                output logic [63:0] d, output logic [7:0] v);
        d = '0; v = '0;
        case (m)
            3'd1, 3'd3: begin
                v[1] = 1; d[15:8]  = pick(k < 2 ? a0 : a1, k);
                v[5] = 1; d[47:40] = pick(k < 2 ? b0 : b1, k);
            end
            3'd2: begin
                v[1] = 1; d[15:8]  = pick(a0, k);
                v[5] = 1; d[47:40] = pick(b0, k);
            end
            3'd5: begin
                v[1] = 1; d[15:8] = pick(k < 2 ? a0 : b0, k);
            end
            default: begin
                v[1] = 1; d[15:8]  = pick(a0, k);
                v[0] = 1; d[7:0]   = pick(a1, k);
                v[5] = 1; d[47:40] = pick(b0, k);
                v[4] = 1; d[39:32] = pick(b1, k);
            end
        endcase
    endtask

    task automatic check_octet(input string req, input logic [2:0] m, input int k,
                               input logic [15:0] a0, a1, b0, b1);
        logic [63:0] d;
        logic [7:0]  v;
        expect_octet(m, k, a0, a1, b0, b1, d, v);
        chk({req, " data"}, lane_octet, d);
        chk({req, " valid"}, {56'd0, lane_vld}, {56'd0, v});
        chk({req, " sof"}, {63'd0, frame_start}, {63'd0, (k == 0)});
    endtask

    task automatic check_idle(input string req);
        chk({req, " idle valid"}, {56'd0, lane_vld}, 64'd0);
        chk({req, " idle data"}, lane_octet, 64'd0);
        chk({req, " idle sof"}, {63'd0, frame_start}, 64'd0);
        chk({req, " idle ready"}, {63'd0, smp_ready}, 64'd1);
    endtask

    // One isolated frame: accept, then check every octet, then the drain.
    task automatic frame_test(input string req, input logic [2:0] m,
                              input logic [15:0] a0, a1, b0, b1);
        @(negedge clk);
        mode_sel = m; smp_valid = 1;
        a_first = a0; a_second = a1; b_first = b0; b_second = b1;
        chk({req, " ready before"}, {63'd0, smp_ready}, 64'd1);
        @(negedge clk);
        smp_valid = 0;
        for (int k = 0; k < flen(m); k++) begin
            if (k > 0) @(negedge clk);
            check_octet(req, m, k, a0, a1, b0, b1);
        end
        @(negedge clk);
        check_idle(req);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check_idle("R13");
    endtask

    task automatic test_back_to_back();   // R10, two frames in mode 0
        @(negedge clk);
        mode_sel = 0; smp_valid = 1;
        a_first = 16'h1122; a_second = 16'h3344; b_first = 16'h5566; b_second = 16'h7788;
        @(negedge clk);
        a_first = 16'h99AA; a_second = 16'hBBCC; b_first = 16'hDDEE; b_second = 16'hF001;
        chk("R10 ready low octet0", {63'd0, smp_ready}, 64'd0);
        check_octet("R10 f1", 3'd0, 0, 16'h1122, 16'h3344, 16'h5566, 16'h7788);
        @(negedge clk);
        chk("R10 ready high last", {63'd0, smp_ready}, 64'd1);
        check_octet("R10 f1", 3'd0, 1, 16'h1122, 16'h3344, 16'h5566, 16'h7788);
        @(negedge clk);
        smp_valid = 0;
        check_octet("R10 f2", 3'd0, 0, 16'h99AA, 16'hBBCC, 16'hDDEE, 16'hF001);
        @(negedge clk);
        check_octet("R10 f2", 3'd0, 1, 16'h99AA, 16'hBBCC, 16'hDDEE, 16'hF001);
        @(negedge clk);
        check_idle("R10");
    endtask

    task automatic test_mode_hold();      // R11
        @(negedge clk);
        mode_sel = 1; smp_valid = 1;
        a_first = 16'hA1A2; a_second = 16'hA3A4; b_first = 16'hB1B2; b_second = 16'hB3B4;
        @(negedge clk);
        smp_valid = 0;
        check_octet("R11 f1", 3'd1, 0, 16'hA1A2, 16'hA3A4, 16'hB1B2, 16'hB3B4);
        @(negedge clk);
        mode_sel = 5;
        check_octet("R11 f1", 3'd1, 1, 16'hA1A2, 16'hA3A4, 16'hB1B2, 16'hB3B4);
        @(negedge clk);
        check_octet("R11 f1", 3'd1, 2, 16'hA1A2, 16'hA3A4, 16'hB1B2, 16'hB3B4);
        @(negedge clk);
        mode_sel = 2; smp_valid = 1;
        a_first = 16'hC1C2; a_second = 16'hC3C4; b_first = 16'hD1D2; b_second = 16'hD3D4;
        chk("R11 ready last", {63'd0, smp_ready}, 64'd1);
        check_octet("R11 f1", 3'd1, 3, 16'hA1A2, 16'hA3A4, 16'hB1B2, 16'hB3B4);
        @(negedge clk);
        smp_valid = 0;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            check_octet("R11 chained", 3'd1, k, 16'hC1C2, 16'hC3C4, 16'hD1D2, 16'hD3D4);
        end
        @(negedge clk);
        check_idle("R11");
        frame_test("R11 after drain", 3'd5, 16'h0F1E, 16'h2D3C, 16'h4B5A, 16'h6978);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected done", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        test_reset();
        frame_test("R1 R2", 3'd0, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);
        frame_test("R3", 3'd1, 16'h0102, 16'h0304, 16'h0506, 16'h0708);
        frame_test("R4", 3'd2, 16'hCAFE, 16'hFFFF, 16'hBEEF, 16'hFFFF);
        frame_test("R5", 3'd3, 16'h1357, 16'h2468, 16'h9BDF, 16'hACE0);
        frame_test("R6", 3'd4, 16'h4321, 16'h8765, 16'hCBA9, 16'h0FED);
        frame_test("R7", 3'd5, 16'hAB12, 16'hEEEE, 16'hCD34, 16'hEEEE);
        frame_test("R8", 3'd4, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        frame_test("R12 code6", 3'd6, 16'h6161, 16'h6262, 16'h6363, 16'h6464);
        frame_test("R12 code7", 3'd7, 16'h7171, 16'h7272, 16'h7373, 16'h7474);
        test_back_to_back();
        test_mode_hold();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule